// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block decides, every cycle, whether the two oldest pre-decoded instructions in an in-order issue queue can leave together. The older one sits in the U slot and the younger one in the V slot. Each slot offers a descriptor with these fields: a valid bit, a class code, destination and source register masks, flag read and flag write masks, and eight attribute bits. The block returns `pair_ok`. When the pair is refused, it also returns a 4-bit code that names the rule that refused it. On a refusal the issue logic sends only the U instruction and shifts the V instruction up into the U slot.

The rules fall into four groups. Class rules forbid mixing integer and floating-point work, and they forbid complex (sequenced) instructions. Slot rules stop prefixes and shifts from issuing in V, stop a branch in U from taking a partner, and stop any instruction that carries both a displacement and an immediate. Hazard rules catch register RAW/WAW and flag RAW dependencies. Named exceptions let some dependent pairs through: a stack operation may pair with a stack operation, a compare may pair with the conditional branch that tests it, and a simple floating-point operation may pair with an exchange. Several rules can fail at once, and a fixed priority then picks the code to report. A parameter selects whether the result is registered (one clock of latency) or combinational.

Top module: `pair_issue_chk`

## Requirements
- R1: With `REG_OUT`=1, both outputs are 0 while `rst_n` is low, and each result appears on the clock edge that follows the inputs it was computed from.
- R2: If either slot's valid bit is 0, `pair_ok` is 0 and `reason` is 0.
- R3: Class codes are 0 = integer ALU/move, 1 = compare, 2 = stack push/pop, 3 = floating-point, 4 = complex. A pair where exactly one slot is class 3 is refused with reason 1. A pair where both slots are class 3 is refused with reason 1 unless U has attribute bit 6 (simple FP) and V has attribute bit 7 (exchange).
- R4: Either slot in class 4 refuses the pair with reason 2.
- R5: U with attribute bit 4 (branch) refuses the pair with reason 3.
- R6: Either slot with both attribute bit 1 (displacement) and attribute bit 2 (immediate) refuses the pair with reason 4.
- R7: V with attribute bit 0 (prefix) refuses the pair with reason 5, unless V also has bit 4 (branch) and bit 5 (conditional).
- R8: V with attribute bit 3 (shift) refuses the pair with reason 6.
- R9: A bit set in U's destination mask that is also set in V's source or destination mask refuses the pair with reason 7. When both slots are class 2, the stack pointer bit (`SP_IDX`) is left out of this test.
- R10: A bit set in U's flag write mask that is also set in V's flag read mask refuses the pair with reason 8, unless U is class 1 and V has bits 4 and 5 set.
- R11: When several rules fail, the lowest reason code is reported. When both slots are valid and no rule fails, `pair_ok` is 1 and `reason` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_valid | input | 1 | U slot holds an instruction |
| u_cls | input | 3 | U class code |
| u_dst | input | NREG | U destination register mask |
| u_src | input | NREG | U source register mask |
| u_flg_rd | input | NFLG | U flag read mask |
| u_flg_wr | input | NFLG | U flag write mask |
| u_attr | input | 8 | U attribute bits |
| v_valid | input | 1 | V slot holds an instruction |
| v_cls | input | 3 | V class code |
| v_dst | input | NREG | V destination register mask |
| v_src | input | NREG | V source register mask |
| v_flg_rd | input | NFLG | V flag read mask |
| v_flg_wr | input | NFLG | V flag write mask |
| v_attr | input | 8 | V attribute bits |
| pair_ok | output | 1 | Both instructions may issue together |
| reason | output | 4 | Code of the highest-priority failing rule, 0 when the pair is allowed or a slot is empty |

## Verification
The block holds no state except the optional output register, so any fault appears on the ports in the very next cycle, on the input pattern that triggers it. A wrong exception mask shows up in one of two ways. Either a stack or compare/branch pair is refused with reason 7 or 8, or a real hazard is let through with `pair_ok` high. A wrong priority order reports a higher code whenever two rules fail together. For these reasons the bench sweeps class pairs against attribute combinations, and sweeps register and flag masks bit by bit, comparing every cycle against a model built from the rule list.

// File: rtl/pair_pkg.sv
package pair_pkg;

  localparam int CLS_W     = 3;
  localparam int ATTR_W    = 8;
  localparam int REASON_W  = 4;
  localparam int NUM_RULES = 8;

  // class codes
  typedef enum logic [CLS_W-1:0] {
    CLS_ALU     = 3'd0,
    CLS_CMP     = 3'd1,
    CLS_STACK   = 3'd2,
    CLS_FP      = 3'd3,
    CLS_COMPLEX = 3'd4
  } cls_e;

  // attribute bit positions
  localparam int A_PFX    = 0;
  localparam int A_DISP   = 1;
  localparam int A_IMM    = 2;
  localparam int A_SHIFT  = 3;
  localparam int A_BRANCH = 4;
  localparam int A_COND   = 5;
  localparam int A_FPS    = 6;
  localparam int A_FXCH   = 7;

  // reason codes, in priority order (lowest wins)
  localparam logic [REASON_W-1:0] RSN_NONE    = 4'd0;
  localparam logic [REASON_W-1:0] RSN_FPMIX   = 4'd1;
  localparam logic [REASON_W-1:0] RSN_COMPLEX = 4'd2;
  localparam logic [REASON_W-1:0] RSN_UBR     = 4'd3;
  localparam logic [REASON_W-1:0] RSN_DISPIMM = 4'd4;
  localparam logic [REASON_W-1:0] RSN_VPFX    = 4'd5;
  localparam logic [REASON_W-1:0] RSN_VSHIFT  = 4'd6;
  localparam logic [REASON_W-1:0] RSN_REG     = 4'd7;
  localparam logic [REASON_W-1:0] RSN_FLAG    = 4'd8;

  // lowest-numbered set bit of the failure vector, 0 if none
  function automatic logic [REASON_W-1:0] first_fail(input logic [NUM_RULES:1] f);
    logic [REASON_W-1:0] r;
    r = RSN_NONE;
    for (int i = NUM_RULES; i >= 1; i--) begin
      if (f[i]) r = REASON_W'(i);
    end
    return r;
  endfunction

  // true when any bit is common to the two masks
  function automatic logic overlap(input logic [63:0] a, input logic [63:0] b);
    return |(a & b);
  endfunction

endpackage

// File: rtl/pair_class_chk.sv
module pair_class_chk
  import pair_pkg::*;
(
  input  logic [CLS_W-1:0] u_cls,
  input  logic [CLS_W-1:0] v_cls,
  input  logic             u_fp_simple,
  input  logic             v_fxch,
  output logic             fp_mix_fail,
  output logic             complex_fail
);

  logic u_is_fp;
  logic v_is_fp;
  logic fxch_pair;
  logic u_complex;
  logic v_complex;

  assign u_is_fp   = (u_cls == CLS_FP);
  assign v_is_fp   = (v_cls == CLS_FP);
  assign fxch_pair = u_is_fp & v_is_fp & u_fp_simple & v_fxch;

  // integer with FP never pairs; FP with FP only in the exchange form
  assign fp_mix_fail = (u_is_fp ^ v_is_fp) | (u_is_fp & v_is_fp & ~fxch_pair);

  assign u_complex    = (u_cls == CLS_COMPLEX);
  assign v_complex    = (v_cls == CLS_COMPLEX);
  assign complex_fail = u_complex | v_complex;

endmodule

// File: rtl/pair_slot_chk.sv
module pair_slot_chk
  import pair_pkg::*;
(
  input  logic u_branch,
  input  logic u_disp,
  input  logic u_imm,
  input  logic v_disp,
  input  logic v_imm,
  input  logic v_prefix,
  input  logic v_jcc,
  input  logic v_shift,
  output logic u_branch_fail,
  output logic disp_imm_fail,
  output logic v_prefix_fail,
  output logic v_shift_fail
);

  localparam int NSLOT = 2;

  logic [NSLOT-1:0] disp_bits;
  logic [NSLOT-1:0] imm_bits;
  logic [NSLOT-1:0] both_di;

  assign disp_bits = {v_disp, u_disp};
  assign imm_bits  = {v_imm, u_imm};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign both_di[s] = disp_bits[s] & imm_bits[s];
  end

  assign disp_imm_fail = |both_di;
  assign u_branch_fail = u_branch;
  // only a prefixed conditional jump may take the V slot
  assign v_prefix_fail = v_prefix & ~v_jcc;
  assign v_shift_fail  = v_shift;

endmodule

// File: rtl/pair_dep_chk.sv
module pair_dep_chk #(
  parameter int NREG   = 8,
  parameter int NFLG   = 6,
  parameter int SP_IDX = 4
) (
  input  logic [NREG-1:0] u_dst,
  input  logic [NREG-1:0] v_src,
  input  logic [NREG-1:0] v_dst,
  input  logic [NFLG-1:0] u_flg_wr,
  input  logic [NFLG-1:0] v_flg_rd,
  input  logic            stack_pair,
  input  logic            u_is_cmp,
  input  logic            v_jcc,
  output logic            reg_fail,
  output logic            flag_fail
);
  import pair_pkg::*;

  logic [NREG-1:0] v_touch;
  logic [NREG-1:0] reg_hit;
  logic            flag_raw;
  logic            cmp_branch;

  assign v_touch = v_src | v_dst;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == SP_IDX) begin : g_sp
      // stack pointer conflict forgiven between two stack operations
      assign reg_hit[i] = u_dst[i] & v_touch[i] & ~stack_pair;
    end else begin : g_gpr
      assign reg_hit[i] = u_dst[i] & v_touch[i];
    end
  end

  assign reg_fail   = |reg_hit;
  assign flag_raw   = overlap(64'(u_flg_wr), 64'(v_flg_rd));
  assign cmp_branch = u_is_cmp & v_jcc;
  assign flag_fail  = flag_raw & ~cmp_branch;

endmodule

// File: rtl/pair_prio.sv
module pair_prio
  import pair_pkg::*;
(
  input  logic [NUM_RULES:1]  fail_vec,
  output logic [REASON_W-1:0] rsn,
  output logic                any_fail
);

  assign rsn      = first_fail(fail_vec);
  assign any_fail = |fail_vec;

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk
  import pair_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int NFLG    = 6,
  parameter int SP_IDX  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                u_valid,
  input  logic [CLS_W-1:0]    u_cls,
  input  logic [NREG-1:0]     u_dst,
  input  logic [NREG-1:0]     u_src,
  input  logic [NFLG-1:0]     u_flg_rd,
  input  logic [NFLG-1:0]     u_flg_wr,
  input  logic [ATTR_W-1:0]   u_attr,
  input  logic                v_valid,
  input  logic [CLS_W-1:0]    v_cls,
  input  logic [NREG-1:0]     v_dst,
  input  logic [NREG-1:0]     v_src,
  input  logic [NFLG-1:0]     v_flg_rd,
  input  logic [NFLG-1:0]     v_flg_wr,
  input  logic [ATTR_W-1:0]   v_attr,
  output logic                pair_ok,
  output logic [REASON_W-1:0] reason
);

  logic                both_valid;
  logic                v_jcc;
  logic                stack_pair;
  logic                u_is_cmp;
  logic [NUM_RULES:1]  fail_vec;
  logic [REASON_W-1:0] rsn;
  logic                any_fail;
  logic                ok_d;
  logic [REASON_W-1:0] reason_d;
  logic                unused_fields;

  assign both_valid = u_valid & v_valid;
  assign v_jcc      = v_attr[A_BRANCH] & v_attr[A_COND];
  assign stack_pair = (u_cls == CLS_STACK) & (v_cls == CLS_STACK);
  assign u_is_cmp   = (u_cls == CLS_CMP);

  // fields carried by the descriptor that no rule reads
  assign unused_fields = ^{u_src, u_flg_rd, v_flg_wr, u_attr[A_PFX], u_attr[A_SHIFT],
                           u_attr[A_COND], u_attr[A_FXCH], v_attr[A_FPS]};

  pair_class_chk i_class (
    .u_cls        (u_cls),
    .v_cls        (v_cls),
    .u_fp_simple  (u_attr[A_FPS]),
    .v_fxch       (v_attr[A_FXCH]),
    .fp_mix_fail  (fail_vec[1]),
    .complex_fail (fail_vec[2])
  );

  pair_slot_chk i_slot (
    .u_branch      (u_attr[A_BRANCH]),
    .u_disp        (u_attr[A_DISP]),
    .u_imm         (u_attr[A_IMM]),
    .v_disp        (v_attr[A_DISP]),
    .v_imm         (v_attr[A_IMM]),
    .v_prefix      (v_attr[A_PFX]),
    .v_jcc         (v_jcc),
    .v_shift       (v_attr[A_SHIFT]),
    .u_branch_fail (fail_vec[3]),
    .disp_imm_fail (fail_vec[4]),
    .v_prefix_fail (fail_vec[5]),
    .v_shift_fail  (fail_vec[6])
  );

  pair_dep_chk #(
    .NREG   (NREG),
    .NFLG   (NFLG),
    .SP_IDX (SP_IDX)
  ) i_dep (
    .u_dst      (u_dst),
    .v_src      (v_src),
    .v_dst      (v_dst),
    .u_flg_wr   (u_flg_wr),
    .v_flg_rd   (v_flg_rd),
    .stack_pair (stack_pair),
    .u_is_cmp   (u_is_cmp),
    .v_jcc      (v_jcc),
    .reg_fail   (fail_vec[7]),
    .flag_fail  (fail_vec[8])
  );

  pair_prio i_prio (
    .fail_vec (fail_vec),
    .rsn      (rsn),
    .any_fail (any_fail)
  );

  assign ok_d     = both_valid & ~any_fail;
  assign reason_d = both_valid ? rsn : RSN_NONE;

  if (REG_OUT) begin : g_reg_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pair_ok <= 1'b0;
        reason  <= RSN_NONE;
      end else begin
        pair_ok <= ok_d;
        reason  <= reason_d;
      end
    end

    // R11
    ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok |-> (reason == RSN_NONE));
    // R2
    no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(u_valid && v_valid) |=> (!pair_ok && reason == RSN_NONE));
    // R5
    u_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid && v_valid && u_attr[A_BRANCH]) |=> !pair_ok);
    // R11
    fail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both_valid && (|fail_vec)) |=> (!pair_ok && reason != RSN_NONE));
    // R3
    fp_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid && v_valid && ((u_cls == CLS_FP) != (v_cls == CLS_FP))) |=> (reason == RSN_FPMIX));
  end else begin : g_comb_out
    assign pair_ok = ok_d;
    assign reason  = reason_d;

    // R11
    ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok |-> (reason == RSN_NONE));
    // R2
    no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(u_valid && v_valid) |-> (!pair_ok && reason == RSN_NONE));
    // R5
    u_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid && v_valid && u_attr[A_BRANCH]) |-> !pair_ok);
    // R3
    fp_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid && v_valid && ((u_cls == CLS_FP) != (v_cls == CLS_FP))) |-> (reason == RSN_FPMIX));
  end

endmodule

// File: tb/test_pair_issue_chk.sv
module test_pair_issue_chk;

  typedef struct packed {
    logic       valid;
    logic [2:0] cls;
    logic [7:0] dst;
    logic [7:0] src;
    logic [5:0] fr;
    logic [5:0] fw;
    logic [7:0] attr;
  } desc_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  desc_t      ud, vd;
  logic       pair_ok;
  logic [3:0] reason;

  int checks = 0;
  int fails  = 0;

  logic       have_prev = 1'b0;
  logic       exp_ok;
  logic [3:0] exp_rsn;
  int         exp_req;

  always #10 clk = ~clk;

  pair_issue_chk i_pair_issue_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .u_valid  (ud.valid),
    .u_cls    (ud.cls),
    .u_dst    (ud.dst),
    .u_src    (ud.src),
    .u_flg_rd (ud.fr),
    .u_flg_wr (ud.fw),
    .u_attr   (ud.attr),
    .v_valid  (vd.valid),
    .v_cls    (vd.cls),
    .v_dst    (vd.dst),
    .v_src    (vd.src),
    .v_flg_rd (vd.fr),
    .v_flg_wr (vd.fw),
    .v_attr   (vd.attr),
    .pair_ok  (pair_ok),
    .reason   (reason)
  );

  // rule model written from the requirement list, first match wins (R11)
  function automatic logic [3:0] model(input desc_t u, input desc_t v);
    logic [7:0] keep;
    bit uf, vf;
    uf = (u.cls == 3'd3);
    vf = (v.cls == 3'd3);
    if (!u.valid || !v.valid) return 4'd0;                      // R2
    if (uf != vf) return 4'd1;                                  // R3
    if (uf && vf && !(u.attr[6] && v.attr[7])) return 4'd1;     // R3
    if (u.cls == 3'd4 || v.cls == 3'd4) return 4'd2;            // R4
    if (u.attr[4]) return 4'd3;                                 // R5
    if ((u.attr[1] && u.attr[2]) || (v.attr[1] && v.attr[2])) return 4'd4; // R6
    if (v.attr[0] && !(v.attr[4] && v.attr[5])) return 4'd5;    // R7
    if (v.attr[3]) return 4'd6;                                 // R8
    keep = (u.cls == 3'd2 && v.cls == 3'd2) ? 8'hEF : 8'hFF;    // R9 stack pointer is bit 4
    if ((u.dst & (v.src | v.dst) & keep) != 8'h00) return 4'd7; // R9
    if ((u.fw & v.fr) != 6'h00 && !(u.cls == 3'd1 && v.attr[4] && v.attr[5])) return 4'd8; // R10
    return 4'd0;
  endfunction

  task automatic check_prev();
    checks++;
    if (pair_ok !== exp_ok || reason !== exp_rsn) begin
      fails++;
      $display("FAIL R%0d: pair_ok=%0b reason=%0d expected pair_ok=%0b reason=%0d",
               exp_req, pair_ok, reason, exp_ok, exp_rsn);
    end
  endtask

  // one vector per cycle: check the previous result, then drive the next (R1 latency)
  task automatic step(input desc_t u, input desc_t v);
    @(negedge clk);
    if (have_prev) check_prev();
    ud = u;
    vd = v;
    exp_rsn = model(u, v);
    exp_ok  = u.valid && v.valid && (exp_rsn == 4'd0);
    if (!(u.valid && v.valid)) exp_req = 2;
    else if (exp_rsn == 4'd0) exp_req = 11;
    else exp_req = int'(exp_rsn) + 2;
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    desc_t u, v;
    // reset with a pair that would otherwise be accepted
    ud = '0; vd = '0;
    ud.valid = 1'b1; vd.valid = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (pair_ok !== 1'b0 || reason !== 4'd0) begin
      fails++;
      $display("FAIL R1: reset pair_ok=%0b reason=%0d expected pair_ok=0 reason=0", pair_ok, reason);
    end
    rst_n = 1'b1;

    // sweep A: every class pair against U attributes and derived V attributes (R3..R8, R11)
    for (int uc = 0; uc < 5; uc++) begin
      for (int vc = 0; vc < 5; vc++) begin
        for (int ua = 0; ua < 256; ua++) begin
          for (int k = 0; k < 16; k++) begin
            u = '0; v = '0;
            u.valid = 1'b1; v.valid = 1'b1;
            u.cls = 3'(uc); v.cls = 3'(vc);
            u.attr = 8'(ua);
            v.attr = 8'(k * 29 + ua * 7);
            step(u, v);
          end
        end
      end
    end

    // sweep B: register and flag masks with stack and compare exceptions (R9, R10)
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int a = 0; a < 2; a++) begin
            u = '0; v = '0;
            u.valid = 1'b1; v.valid = 1'b1;
            case (p)
              0: begin u.cls = 3'd0; v.cls = 3'd0; end
              1: begin u.cls = 3'd2; v.cls = 3'd2; end
              2: begin u.cls = 3'd1; v.cls = 3'd0; end
              default: begin u.cls = 3'd0; v.cls = 3'd2; end
            endcase
            u.dst = 8'(i);
            u.src = 8'(i * 3);
            v.src = 8'(1 << j);
            v.dst = j[0] ? 8'h10 : 8'h00;
            u.fw  = 6'(1 << (j % 6));
            v.fr  = 6'(i);
            v.attr = (a == 1) ? 8'h30 : 8'h00;
            step(u, v);
          end
        end
      end
    end

    // sweep C: slot valid combinations (R2)
    for (int vb = 0; vb < 4; vb++) begin
      for (int n = 0; n < 64; n++) begin
        u = '0; v = '0;
        u.valid = vb[0]; v.valid = vb[1];
        u.cls = 3'(n % 5); v.cls = 3'((n / 5) % 5);
        u.attr = 8'(n * 11); v.attr = 8'(n * 13);
        u.dst = 8'(n); v.src = 8'(n * 5);
        u.fw = 6'(n); v.fr = 6'(n * 3);
        step(u, v);
      end
    end

    @(negedge clk);
    check_prev();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule